// File: doc/BRIEF.md
# Absolute Value and Difference-or-Zero Unit

This block is a combinational integer arithmetic unit for two legacy operations on signed 32-bit operands. The absolute-value operation returns the magnitude of operand A. The one value with no positive counterpart, the most negative number, passes through unchanged, and in that case the unit can report an overflow. The difference-or-zero operation returns zero when operand A is the larger of the pair in a signed comparison. Otherwise it returns the second operand minus A, formed as the complement of A plus the second operand plus one. The second operand is either a register value or a sign-extended 16-bit immediate.

An execution stage drives the operands and flags and takes the result in the same cycle. The unit holds one sticky summary-overflow bit. This bit is the only clocked state in the block. It feeds the summary bit of a 4-bit condition field, which is produced whenever the record flag is set.

Top module: `absdoz_unit`

## Requirements
- R1: With opSel = 0 (absolute value) and opA not equal to 0x8000_0000, result equals the magnitude of opA read as a signed number.
- R2: With opSel = 0 and opA = 0x8000_0000, result is 0x8000_0000.
- R3: ovOut is 1 exactly when opSel = 0, opA = 0x8000_0000 and ovEnable = 1. In every other case, including all difference-or-zero operations, it is 0.
- R4: With opSel = 1 (difference-or-zero), if opA is greater than the second operand in a signed 32-bit comparison, result is 0.
- R5: With opSel = 1 and opA not greater than the second operand, result is NOT(opA) + second operand + 1, taken modulo 2^32.
- R6: When immSel = 1, the second operand of difference-or-zero is immVal sign-extended to 32 bits, and opB has no effect on result. When immSel = 0, opB is used.
- R7: The sticky summary-overflow bit is set at the first rising clock edge at which ovOut is 1. It stays set until rstN is driven low, and rstN low clears it.
- R8: When recordEn = 1, condField[3] (LT), condField[2] (GT) and condField[1] (EQ) report the signed comparison of result against zero, and exactly one of the three is 1.
- R9: When recordEn = 1, condField[0] (SO) is the sticky bit OR the current ovOut. When recordEn = 0, condField is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sticky overflow bit |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 1 | 0 = absolute value, 1 = difference-or-zero |
| opA | input | 32 | Operand A |
| opB | input | 32 | Register second operand |
| immVal | input | 16 | Signed immediate second operand |
| immSel | input | 1 | Use the sign-extended immediate instead of opB |
| ovEnable | input | 1 | Allow overflow reporting |
| recordEn | input | 1 | Produce the condition field |
| result | output | 32 | Operation result |
| ovOut | output | 1 | Overflow flag write value |
| condField | output | 4 | {LT, GT, EQ, SO} |

## Verification
The bench builds the unit with its default parameters: a 32-bit data width and a 16-bit immediate. At these widths the edge operands 0, 0x7FFF_FFFF, 0x8000_0000 and 0xFFFF_FFFF are reachable directly, along with equal operand pairs and immediates whose sign extension flips the signed comparison. A reference model inside the bench also tracks the sticky bit across clock edges. It uses that model to check the summary bit before an overflow, after an overflow, and after a reset in the middle of the run.

// File: rtl/absdoz_pkg.sv
package absdoz_pkg;

  typedef enum logic {
    OP_ABS = 1'b0,
    OP_DOZ = 1'b1
  } opKind_e;

  typedef struct packed {
    logic selAbs;
    logic selDoz;
    logic useImm;
    logic allowOv;
    logic recordCond;
  } ctrlStrobes_t;

endpackage

// File: rtl/absdoz_ctrl.sv
module absdoz_ctrl
  import absdoz_pkg::*;
(
  input  logic         opSel,
  input  logic         immSel,
  input  logic         ovEnable,
  input  logic         recordEn,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.selAbs     = (opSel == OP_ABS);
    strobes.selDoz     = (opSel == OP_DOZ);
    // the immediate only matters for difference-or-zero
    strobes.useImm     = (opSel == OP_DOZ) && immSel;
    // only absolute value can overflow
    strobes.allowOv    = (opSel == OP_ABS) && ovEnable;
    strobes.recordCond = recordEn;
  end

endmodule

// File: rtl/absdoz_datapath.sv
module absdoz_datapath
  import absdoz_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int IMM_WIDTH = 16
) (
  input  ctrlStrobes_t       strobes,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [IMM_WIDTH-1:0] immVal,
  output logic [WIDTH-1:0]   result,
  output logic               ovOut
);

  localparam int EXT_BITS = WIDTH - IMM_WIDTH;
  localparam logic [WIDTH-1:0] ONE_VAL = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] immExt;
  logic [WIDTH-1:0] secondOp;
  logic [WIDTH-1:0] absRes;
  logic [WIDTH-1:0] diffRes;
  logic [WIDTH-1:0] dozRes;
  logic             aIsMin;
  logic             aGreater;

  assign immExt   = {{EXT_BITS{immVal[IMM_WIDTH-1]}}, immVal};
  assign secondOp = strobes.useImm ? immExt : opB;

  // two's complement negation; the most negative value maps to itself
  assign absRes   = opA[WIDTH-1] ? (~opA + ONE_VAL) : opA;
  assign aIsMin   = (opA == MIN_VAL);

  assign aGreater = $signed(opA) > $signed(secondOp);
  assign diffRes  = ~opA + secondOp + ONE_VAL;
  assign dozRes   = aGreater ? '0 : diffRes;

  always_comb begin
    result = '0;
    if (strobes.selAbs) result = absRes;
    else if (strobes.selDoz) result = dozRes;
  end

  assign ovOut = strobes.allowOv && aIsMin;

endmodule

// File: rtl/absdoz_cond.sv
module absdoz_cond #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] result,
  input  logic             ovNow,
  input  logic             recordCond,
  output logic [3:0]       condField
);

  logic stickyQ;
  logic resNeg;
  logic resZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= 1'b0;
    else       stickyQ <= stickyQ | ovNow;
  end

  assign resNeg  = result[WIDTH-1];
  assign resZero = (result == '0);

  always_comb begin
    condField = 4'b0000;
    if (recordCond) begin
      condField[3] = resNeg;
      condField[2] = !resNeg && !resZero;
      condField[1] = resZero;
      condField[0] = stickyQ | ovNow;
    end
  end

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyQ |=> stickyQ);

  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovNow |=> stickyQ);

  // R8
  cond_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    recordCond |-> ($countones(condField[3:1]) == 1));

  // R9
  cond_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !recordCond |-> (condField == 4'b0000));

endmodule

// File: rtl/absdoz_unit.sv
module absdoz_unit
  import absdoz_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int IMM_WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opSel,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [IMM_WIDTH-1:0] immVal,
  input  logic                 immSel,
  input  logic                 ovEnable,
  input  logic                 recordEn,
  output logic [WIDTH-1:0]     result,
  output logic                 ovOut,
  output logic [3:0]           condField
);

  localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};

  ctrlStrobes_t strobes;

  absdoz_ctrl u_ctrl (
    .opSel    (opSel),
    .immSel   (immSel),
    .ovEnable (ovEnable),
    .recordEn (recordEn),
    .strobes  (strobes)
  );

  absdoz_datapath #(
    .WIDTH     (WIDTH),
    .IMM_WIDTH (IMM_WIDTH)
  ) u_dp (
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .immVal  (immVal),
    .result  (result),
    .ovOut   (ovOut)
  );

  absdoz_cond #(
    .WIDTH (WIDTH)
  ) u_cond (
    .clk        (clk),
    .rstN       (rstN),
    .result     (result),
    .ovNow      (ovOut),
    .recordCond (recordEn),
    .condField  (condField)
  );

  // R3
  ov_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovOut |-> (opSel == OP_ABS && opA == MIN_VAL && ovEnable));

  // R1
  abs_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_ABS && opA != MIN_VAL) |-> !result[WIDTH-1]);

  // R4
  doz_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_DOZ && !immSel && $signed(opA) > $signed(opB)) |-> (result == '0));

endmodule

// File: tb/sim_absdoz_unit.sv
module sim_absdoz_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MINV = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opSel = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] immVal = '0;
  logic        immSel = 1'b0;
  logic        ovEnable = 1'b0;
  logic        recordEn = 1'b0;
  logic [31:0] result;
  logic        ovOut;
  logic [3:0]  condField;

  int checks = 0;
  int bad = 0;
  logic expSticky = 1'b0;
  logic lastOv = 1'b0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  absdoz_unit u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .opA(opA), .opB(opB),
    .immVal(immVal), .immSel(immSel), .ovEnable(ovEnable), .recordEn(recordEn),
    .result(result), .ovOut(ovOut), .condField(condField)
  );

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operation, compare all outputs with the reference model
  task automatic runOp(string tag, logic op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] imm, logic isImm, logic ovEn, logic rec);
    logic [31:0] bEff, expRes;
    logic expOv;
    logic [3:0] expCond;
    @(negedge clk);
    expSticky = expSticky | lastOv;   // latched at the edge just passed
    opSel = op; opA = a; opB = b; immVal = imm; immSel = isImm;
    ovEnable = ovEn; recordEn = rec;
    #1;
    bEff = isImm ? {{16{imm[15]}}, imm} : b;
    if (op == 1'b0) begin
      expRes = a[31] ? (32'd0 - a) : a;
      expOv  = (a == MINV) && ovEn;
    end else begin
      expRes = ($signed(a) > $signed(bEff)) ? 32'd0 : (bEff - a);
      expOv  = 1'b0;
    end
    expCond = rec ? {expRes[31], (!expRes[31] && expRes != 0), (expRes == 0),
                     (expSticky | expOv)} : 4'b0000;
    lastOv = expOv;
    checkVal({tag, " result"}, result, expRes);
    checkVal({tag, " ovOut"}, {31'd0, ovOut}, {31'd0, expOv});
    checkVal({tag, " condField"}, {28'd0, condField}, {28'd0, expCond});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    opSel = 1'b0; opA = '0; ovEnable = 1'b0; recordEn = 1'b0; immSel = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expSticky = 1'b0;
    lastOv = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    // R9 after reset the summary bit is clear
    runOp("R9 reset", 1'b0, 32'd7, 32'd0, 16'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testAbs();
    runOp("R1 abs zero", 1'b0, 32'd0, 32'd0, 16'd0, 1'b0, 1'b1, 1'b1);
    runOp("R1 abs max", 1'b0, 32'h7FFF_FFFF, 32'd0, 16'd0, 1'b0, 1'b1, 1'b1);
    runOp("R1 abs minus1", 1'b0, 32'hFFFF_FFFF, 32'd0, 16'd0, 1'b0, 1'b1, 1'b0);
    runOp("R1 abs neg", 1'b0, 32'hFFFF_FF85, 32'd5, 16'h1234, 1'b1, 1'b0, 1'b1);
    runOp("R2 R3 abs min no ov", 1'b0, MINV, 32'd0, 16'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testDoz();
    runOp("R4 doz a>b", 1'b1, 32'd10, 32'd3, 16'd0, 1'b0, 1'b1, 1'b1);
    runOp("R5 doz a<b", 1'b1, 32'd3, 32'd10, 16'd0, 1'b0, 1'b1, 1'b1);
    runOp("R5 doz equal", 1'b1, 32'h1234_5678, 32'h1234_5678, 16'd0, 1'b0, 1'b0, 1'b1);
    runOp("R4 doz max>min", 1'b1, 32'h7FFF_FFFF, MINV, 16'd0, 1'b0, 1'b1, 1'b1);
    runOp("R5 doz min<max", 1'b1, MINV, 32'h7FFF_FFFF, 16'd0, 1'b0, 1'b1, 1'b1);
    runOp("R5 doz minus1<0", 1'b1, 32'hFFFF_FFFF, 32'd0, 16'd0, 1'b0, 1'b0, 1'b1);
    runOp("R4 doz 0>minus1", 1'b1, 32'd0, 32'hFFFF_FFFF, 16'd0, 1'b0, 1'b0, 1'b1);
    runOp("R3 doz min never ov", 1'b1, MINV, MINV, 16'd0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testImm();
    // R6 negative immediate sign-extends; opB would give a different answer
    runOp("R6 imm neg", 1'b1, 32'hFFFF_FF00, 32'd0, 16'hFFF0, 1'b1, 1'b0, 1'b1);
    runOp("R6 imm neg a>", 1'b1, 32'd0, 32'hFFFF_0000, 16'h8000, 1'b1, 1'b0, 1'b1);
    runOp("R6 imm pos", 1'b1, 32'd5, 32'hFFFF_FFFF, 16'h7FFF, 1'b1, 1'b0, 1'b1);
    runOp("R6 imm equal", 1'b1, 32'h0000_0042, 32'd1, 16'h0042, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testSticky();
    runOp("R3 R9 abs min ov", 1'b0, MINV, 32'd0, 16'd0, 1'b0, 1'b1, 1'b1);
    runOp("R7 sticky after ov", 1'b0, 32'd5, 32'd0, 16'd0, 1'b0, 1'b0, 1'b1);
    runOp("R7 sticky holds", 1'b1, 32'd9, 32'd9, 16'd0, 1'b0, 1'b0, 1'b1);
    runOp("R9 no record", 1'b0, 32'd5, 32'd0, 16'd0, 1'b0, 1'b0, 1'b0);
    doReset();
    runOp("R7 cleared by reset", 1'b0, 32'd5, 32'd0, 16'd0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    testReset();
    testAbs();
    testDoz();
    testImm();
    testSticky();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule